// File: doc/BRIEF.md
# Save-Memory Timing and Ownership Controller

This block stands in for a cartridge save chip. A small register bank selects which kind of device is being imitated (battery SRAM, a 4 Kbit or 64 Kbit serial EEPROM, or a 512 Kbit or 1 Mbit flash), which of two bus masters currently owns the save window, and how many bus-clock cycles each slow operation takes. The flash command decoder that would sit in front of it is reduced to a start strobe with an operation kind. The controller answers with a busy flag that stays high for the programmed time.

The save window is shared between an emulation-side master (master 0) and a host master (master 1). Only the owner reaches the storage port. The other master reads zero and its writes are dropped. Addresses are folded into the window size of the selected device. The two flash banks of the 1 Mbit device form one contiguous 128 KiB range.

Top module: `save_timing_ctrl`

## Requirements
- R1: After reset the mode reads 0 (SRAM), the owner reads 0, all four duration registers read 0, busy is low and the sticky error bit is clear.
- R2: Configuration registers are written and read back at byte offsets: mode 0x00 (bits 2:0), owner 0x04 (bit 0), status 0x08 (bit 0 sticky error, bit 1 busy), chip-erase count 0x20, sector-erase count 0x24, program count 0x28, EEPROM-write count 0x2C (all 32 bits). Unmapped offsets read 0.
- R3: An accepted start loads a down-counter with the selected count N. Busy rises on the clock edge that takes the start and stays high for exactly N+1 cycles, so N=0 gives one busy cycle.
- R4: The operation kind picks the count: kind 0 chip erase (0x20), kind 1 sector erase (0x24), kind 2 program (0x28), kind 3 EEPROM write (0x2C).
- R5: Mode codes are 0 SRAM, 1 4 Kbit EEPROM, 2 64 Kbit EEPROM, 3 512 Kbit flash, 4 1 Mbit flash. Codes 5 to 7 behave as SRAM. In SRAM behaviour a start never raises busy or the error bit.
- R6: A start whose kind does not fit the mode is ignored without error. In a flash mode only kinds 0 to 2 fit. In an EEPROM mode only kind 3 fits.
- R7: A start while busy is ignored, leaving the running countdown untouched, and sets the sticky error bit. Writing 1 to status bit 0 clears it. When a clear and a new error fall in the same cycle, the error wins.
- R8: Rewriting a duration register while busy does not change the countdown in flight. The new value applies to the next start.
- R9: Owner 0 routes master 0 to the storage port (address, write enable, write data). Owner 1 routes master 1. The owner sees storage read data, and the non-owner reads 0 and never drives a write.
- R10: The storage address is the owner's address folded into the device window: 512 B for the 4 Kbit EEPROM, 8 KiB for the 64 Kbit EEPROM, 32 KiB for SRAM (and codes 5 to 7), 64 KiB for the 512 Kbit flash, and 128 KiB for the 1 Mbit flash as one contiguous range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulated bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| op_start | input | 1 | Operation start strobe |
| op_kind | input | 2 | Operation kind of the start |
| busy | output | 1 | Operation in progress |
| op_err | output | 1 | Sticky overlapping-start error |
| m0_addr | input | 17 | Master 0 save address |
| m0_we | input | 1 | Master 0 write enable |
| m0_wdata | input | 8 | Master 0 write data |
| m0_rdata | output | 8 | Master 0 read data |
| m1_addr | input | 17 | Master 1 save address |
| m1_we | input | 1 | Master 1 write enable |
| m1_wdata | input | 8 | Master 1 write data |
| m1_rdata | output | 8 | Master 1 read data |
| mem_addr | output | 17 | Storage address, folded to the window |
| mem_we | output | 1 | Storage write enable |
| mem_wdata | output | 8 | Storage write data |
| mem_rdata | input | 8 | Storage read data |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a software write that clears the sticky error and a fresh overlapping start. The bench drives both in one cycle during a countdown and expects the error bit still set afterwards, then clears it alone and expects zero. The second pair is a new start and the final busy cycle, when the counter is already at zero. The bench pulses the start exactly there and expects busy to fall on schedule, with no restart and the error bit raised. A duration register rewritten mid-countdown is judged by the total busy length matching the old value.

// File: rtl/save_timing_pkg.sv
`timescale 1ns/1ps
package save_timing_pkg;

    localparam int CFG_AW = 6;
    localparam int CNT_W  = 32;
    localparam int N_OPS  = 4;

    localparam logic [CFG_AW-1:0] OFS_MODE   = 6'h00;
    localparam logic [CFG_AW-1:0] OFS_OWNER  = 6'h04;
    localparam logic [CFG_AW-1:0] OFS_STATUS = 6'h08;
    localparam logic [CFG_AW-1:0] OFS_DUR0   = 6'h20;

    typedef enum logic [2:0] {
        DEV_SRAM     = 3'd0,
        DEV_EE_SMALL = 3'd1,
        DEV_EE_LARGE = 3'd2,
        DEV_FL_HALF  = 3'd3,
        DEV_FL_FULL  = 3'd4
    } dev_kind_e;

    typedef enum logic [1:0] {
        OP_CHIP_ERASE   = 2'd0,
        OP_SECTOR_ERASE = 2'd1,
        OP_PROGRAM      = 2'd2,
        OP_EE_WRITE     = 2'd3
    } op_kind_e;

    function automatic logic dev_is_flash(input logic [2:0] m);
        return (m == DEV_FL_HALF) || (m == DEV_FL_FULL);
    endfunction

    function automatic logic dev_is_eeprom(input logic [2:0] m);
        return (m == DEV_EE_SMALL) || (m == DEV_EE_LARGE);
    endfunction

    function automatic int unsigned window_bits(input logic [2:0] m);
        case (m)
            DEV_EE_SMALL: return 9;
            DEV_EE_LARGE: return 13;
            DEV_FL_HALF:  return 16;
            DEV_FL_FULL:  return 17;
            default:      return 15;
        endcase
    endfunction

endpackage

// File: rtl/save_cfg_regs.sv
`timescale 1ns/1ps
module save_cfg_regs
    import save_timing_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int CW = CNT_W,
    parameter int NOPS = N_OPS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic                     stat_err,
    input  logic                     stat_busy,
    output logic [2:0]               mode,
    output logic                     owner,
    output logic [NOPS-1:0][CW-1:0]  dur,
    output logic                     clr_err
);
    typedef struct packed {
        logic [2:0]              mode;
        logic                    owner;
        logic [NOPS-1:0][CW-1:0] dur;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        clr_err = 1'b0;
        if (we) begin
            if (addr == OFS_MODE)   r_d.mode  = wdata[2:0];
            if (addr == OFS_OWNER)  r_d.owner = wdata[0];
            if (addr == OFS_STATUS) clr_err   = wdata[0];
            for (int i = 0; i < NOPS; i++) begin
                if (addr == AW'(OFS_DUR0 + 4 * i)) r_d.dur[i] = wdata[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_MODE)   rdata = {29'd0, r_q.mode};
        if (addr == OFS_OWNER)  rdata = {31'd0, r_q.owner};
        if (addr == OFS_STATUS) rdata = {30'd0, stat_busy, stat_err};
        for (int i = 0; i < NOPS; i++) begin
            if (addr == AW'(OFS_DUR0 + 4 * i)) rdata = 32'(r_q.dur[i]);
        end
    end

    assign mode  = r_q.mode;
    assign owner = r_q.owner;
    assign dur   = r_q.dur;

    p_owner_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == OFS_OWNER) |=> $stable(owner));

endmodule

// File: rtl/save_busy_timer.sv
`timescale 1ns/1ps
module save_busy_timer
    import save_timing_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NOPS = N_OPS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_start,
    input  logic [1:0]               op_kind,
    input  logic [2:0]               mode,
    input  logic [NOPS-1:0][CW-1:0]  dur,
    input  logic                     clr_err,
    output logic                     busy,
    output logic                     err
);
    typedef struct packed {
        logic          busy;
        logic          err;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_q, s_d;
    logic kind_fits;

    always_comb begin
        if (dev_is_flash(mode))       kind_fits = (op_kind != OP_EE_WRITE);
        else if (dev_is_eeprom(mode)) kind_fits = (op_kind == OP_EE_WRITE);
        else                          kind_fits = 1'b0;
    end

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end else if (op_start && kind_fits) begin
            s_d.busy = 1'b1;
            s_d.cnt  = dur[op_kind];
        end
        if (clr_err)             s_d.err = 1'b0;
        if (op_start && s_q.busy) s_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign err  = s_q.err;

    p_count_continues_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> (s_q.busy && s_q.cnt == $past(s_q.cnt) - 1'b1));

    p_sram_never_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !dev_is_flash(mode) && !dev_is_eeprom(mode)) |=> !s_q.busy);

    p_err_on_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && op_start) |=> s_q.err);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !clr_err) |=> s_q.err);

endmodule

// File: rtl/save_port_mux.sv
`timescale 1ns/1ps
module save_port_mux
    import save_timing_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode,
    input  logic          owner,
    input  logic [AW-1:0] m0_addr,
    input  logic          m0_we,
    input  logic [DW-1:0] m0_wdata,
    output logic [DW-1:0] m0_rdata,
    input  logic [AW-1:0] m1_addr,
    input  logic          m1_we,
    input  logic [DW-1:0] m1_wdata,
    output logic [DW-1:0] m1_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    logic [AW-1:0] win_mask;
    logic [AW-1:0] sel_addr;

    always_comb begin
        for (int i = 0; i < AW; i++) win_mask[i] = (i < window_bits(mode));
    end

    always_comb begin
        sel_addr  = owner ? m1_addr : m0_addr;
        mem_addr  = sel_addr & win_mask;
        mem_we    = owner ? m1_we : m0_we;
        mem_wdata = owner ? m1_wdata : m0_wdata;
        m0_rdata  = owner ? '0 : mem_rdata;
        m1_rdata  = owner ? mem_rdata : '0;
    end

    p_nonowner_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (owner ? (m0_rdata == '0) : (m1_rdata == '0)));

    p_write_from_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (owner ? m1_we : m0_we));

    p_addr_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DEV_EE_SMALL) |-> (mem_addr < AW'(512)));

endmodule

// File: rtl/save_timing_ctrl.sv
`timescale 1ns/1ps
module save_timing_ctrl
    import save_timing_pkg::*;
#(
    parameter int SAVE_AW = 17,
    parameter int SAVE_DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [5:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               op_start,
    input  logic [1:0]         op_kind,
    output logic               busy,
    output logic               op_err,
    input  logic [SAVE_AW-1:0] m0_addr,
    input  logic               m0_we,
    input  logic [SAVE_DW-1:0] m0_wdata,
    output logic [SAVE_DW-1:0] m0_rdata,
    input  logic [SAVE_AW-1:0] m1_addr,
    input  logic               m1_we,
    input  logic [SAVE_DW-1:0] m1_wdata,
    output logic [SAVE_DW-1:0] m1_rdata,
    output logic [SAVE_AW-1:0] mem_addr,
    output logic               mem_we,
    output logic [SAVE_DW-1:0] mem_wdata,
    input  logic [SAVE_DW-1:0] mem_rdata
);
    logic [2:0]                   mode;
    logic                         owner;
    logic [N_OPS-1:0][CNT_W-1:0]  dur;
    logic                         clr_err;

    save_cfg_regs #(.AW(CFG_AW), .CW(CNT_W), .NOPS(N_OPS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .stat_err(op_err), .stat_busy(busy),
        .mode(mode), .owner(owner), .dur(dur), .clr_err(clr_err)
    );

    save_busy_timer #(.CW(CNT_W), .NOPS(N_OPS)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_kind(op_kind), .mode(mode), .dur(dur),
        .clr_err(clr_err), .busy(busy), .err(op_err)
    );

    save_port_mux #(.AW(SAVE_AW), .DW(SAVE_DW)) u_mux (
        .clk(clk), .rst_n(rst_n), .mode(mode), .owner(owner),
        .m0_addr(m0_addr), .m0_we(m0_we), .m0_wdata(m0_wdata), .m0_rdata(m0_rdata),
        .m1_addr(m1_addr), .m1_we(m1_we), .m1_wdata(m1_wdata), .m1_rdata(m1_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

endmodule

// File: tb/tb_save_timing_ctrl.sv
`timescale 1ns/1ps
module tb_save_timing_ctrl;
    localparam int AW = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = '0;
    logic        busy, op_err;
    logic [AW-1:0] m0_addr = '0, m1_addr = '0;
    logic        m0_we = 1'b0, m1_we = 1'b0;
    logic [7:0]  m0_wdata = 8'h11, m1_wdata = 8'h22;
    logic [7:0]  m0_rdata, m1_rdata;
    logic [AW-1:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

    save_timing_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .op_start(op_start),
        .op_kind(op_kind), .busy(busy), .op_err(op_err),
        .m0_addr(m0_addr), .m0_we(m0_we), .m0_wdata(m0_wdata), .m0_rdata(m0_rdata),
        .m1_addr(m1_addr), .m1_we(m1_we), .m1_wdata(m1_wdata), .m1_rdata(m1_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [2:0]    mode;
        logic          owner;
        logic [AW-1:0] a0;
        logic          w0;
        logic [AW-1:0] a1;
        logic          w1;
        logic [AW-1:0] exp_addr;
        logic          exp_we;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 1'b0, 17'h12345, 1'b1, 17'h00FF0, 1'b1, 17'h02345, 1'b1},
        '{3'd1, 1'b0, 17'h00A37, 1'b0, 17'h00001, 1'b1, 17'h00037, 1'b0},
        '{3'd2, 1'b1, 17'h01234, 1'b1, 17'h1F00F, 1'b1, 17'h0100F, 1'b1},
        '{3'd3, 1'b1, 17'h00000, 1'b1, 17'h1ABCD, 1'b0, 17'h0ABCD, 1'b0},
        '{3'd4, 1'b0, 17'h1ABCD, 1'b1, 17'h00000, 1'b0, 17'h1ABCD, 1'b1},
        '{3'd4, 1'b1, 17'h1FFFF, 1'b1, 17'h08001, 1'b1, 17'h08001, 1'b1},
        '{3'd6, 1'b0, 17'h1FFFF, 1'b0, 17'h00000, 1'b1, 17'h07FFF, 1'b0},
        '{3'd3, 1'b0, 17'h0FFFF, 1'b1, 17'h10000, 1'b0, 17'h0FFFF, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // start one operation and count the busy cycles that follow
    task automatic run_op(input logic [1:0] kind, output int cyc);
        @(negedge clk);
        op_start = 1'b1; op_kind = kind;
        @(negedge clk);
        op_start = 1'b0;
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cfg_read(6'h00, rd); check("R1 mode", rd, 0);
        cfg_read(6'h04, rd); check("R1 owner", rd, 0);
        cfg_read(6'h08, rd); check("R1 status", rd, 0);
        for (int i = 0; i < 4; i++) begin
            cfg_read(6'(6'h20 + 4 * i), rd); check("R1 duration", rd, 0);
        end
        check("R1 busy/err", {busy, op_err}, 0);

        // R9 R10 routing and folding vectors
        for (int v = 0; v < 8; v++) begin
            cfg_write(6'h00, {29'd0, VECS[v].mode});
            cfg_write(6'h04, {31'd0, VECS[v].owner});
            m0_addr = VECS[v].a0; m0_we = VECS[v].w0;
            m1_addr = VECS[v].a1; m1_we = VECS[v].w1;
            #1;
            check("R10 mem_addr", mem_addr, VECS[v].exp_addr);
            check("R9 mem_we", mem_we, VECS[v].exp_we);
            check("R9 mem_wdata", mem_wdata, VECS[v].owner ? 8'h22 : 8'h11);
            check("R9 m0_rdata", m0_rdata,
                  VECS[v].owner ? 8'h00 : (VECS[v].exp_addr[7:0] ^ 8'h5A));
            check("R9 m1_rdata", m1_rdata,
                  VECS[v].owner ? (VECS[v].exp_addr[7:0] ^ 8'h5A) : 8'h00);
        end
        m0_we = 1'b0; m1_we = 1'b0;

        // R2 register readback
        cfg_write(6'h20, 32'd7);
        cfg_write(6'h24, 32'd2);
        cfg_write(6'h28, 32'd5);
        cfg_write(6'h2C, 32'd9);
        cfg_write(6'h00, 32'hFFFF_FFFB);
        cfg_read(6'h00, rd); check("R2 mode field", rd, 3);
        cfg_read(6'h20, rd); check("R2 chip erase reg", rd, 7);
        cfg_read(6'h2C, rd); check("R2 ee write reg", rd, 9);
        cfg_read(6'h10, rd); check("R2 unmapped", rd, 0);

        // R3 R4 flash kinds in flash mode
        run_op(2'd0, cyc); check("R4 chip erase N=7", cyc, 8);
        run_op(2'd1, cyc); check("R4 sector erase N=2", cyc, 3);
        run_op(2'd2, cyc); check("R4 program N=5", cyc, 6);
        cfg_write(6'h28, 32'd0);
        run_op(2'd2, cyc); check("R3 zero count", cyc, 1);
        cfg_write(6'h00, 32'd2);
        run_op(2'd3, cyc); check("R4 eeprom write N=9", cyc, 10);

        // R6 mismatched kinds
        run_op(2'd0, cyc); check("R6 flash op in eeprom mode", cyc, 0);
        cfg_write(6'h00, 32'd4);
        run_op(2'd3, cyc); check("R6 eeprom op in flash mode", cyc, 0);
        check("R6 no error", op_err, 0);

        // R5 SRAM and unused codes
        cfg_write(6'h00, 32'd0);
        run_op(2'd0, cyc); check("R5 sram", cyc, 0);
        cfg_write(6'h00, 32'd7);
        run_op(2'd3, cyc); check("R5 code 7", cyc, 0);
        check("R5 no error", op_err, 0);

        // R7 overlapping start mid-countdown
        cfg_write(6'h00, 32'd3);
        cfg_write(6'h20, 32'd5);
        @(negedge clk); op_start = 1'b1; op_kind = 2'd0; cyc = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            op_start = (i == 2);
            if (busy) cyc++;
        end
        check("R7 countdown kept", cyc, 6);
        cfg_read(6'h08, rd); check("R7 sticky err", rd, 1);

        cfg_write(6'h08, 32'd1);
        check("R7 cleared", op_err, 0);

        // R7 start in the last busy cycle
        cfg_write(6'h20, 32'd2);
        @(negedge clk); op_start = 1'b1; cyc = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            op_start = (i == 2);
            if (busy) cyc++;
        end
        check("R7 last-cycle start ignored", cyc, 3);
        check("R7 last-cycle err", op_err, 1);

        // R7 clear and new error in the same cycle
        cfg_write(6'h20, 32'd4);
        @(negedge clk); op_start = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            op_start  = (i == 1);
            cfg_we    = (i == 1);
            cfg_addr  = 6'h08;
            cfg_wdata = 32'd1;
        end
        check("R7 set beats clear", op_err, 1);
        cfg_write(6'h08, 32'd1);
        check("R7 clear alone", op_err, 0);

        // R8 rewrite during countdown
        cfg_write(6'h24, 32'd3);
        @(negedge clk); op_start = 1'b1; op_kind = 2'd1; cyc = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            op_start  = 1'b0;
            cfg_we    = (i == 0);
            cfg_addr  = 6'h24;
            cfg_wdata = 32'd50;
            if (busy) cyc++;
        end
        check("R8 running count unchanged", cyc, 4);
        run_op(2'd1, cyc); check("R8 new count next start", cyc, 51);
        check("R8 no error", op_err, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule